// File: doc/BRIEF.md
# Streaming Executable Image Loader

This block brings a processor's memory to its starting state from an executable image that arrives one byte per handshake. The image opens with a fixed-length header: a two-byte signature, a revision byte, a pointer-size byte, and two little-endian pointers. The first pointer marks where the stored bytes stop (end-of-file). The second marks where the zero-initialised working area ends (end-of-memory). Every byte up to end-of-file, header included, is written to memory at the address equal to its offset in the image.

Once the stored bytes are in place, the loader writes zeros itself over the range from end-of-file up to end-of-memory, because those bytes are never carried in the image. It then raises a one-cycle completion pulse and presents the start address for execution. An image that is malformed or cut short stops the load and produces an error code that names the cause. A new load starts only after reset.

Top module: `image_boot_loader`

## Requirements
- R1: Image byte 0 must be 0x52 and byte 1 must be 0x57. Any other value sets `load_err` with `err_code` 1, and the offending byte is not written.
- R2: Byte 2 must equal 97 plus the accepted revision (default 1, so 98). Any other value gives `err_code` 2, and the byte is not written.
- R3: Byte 3 must equal 48 plus log2 of the pointer width in bytes (default 4 bytes, so 50). Any other value gives `err_code` 3, and the byte is not written.
- R4: End-of-file is taken little-endian from offsets 4..7 and end-of-memory from offsets 8..11. Every accepted byte at an offset below end-of-file is written with `mem_addr` equal to that offset, in order and unmodified, header bytes included.
- R5: Once the last stored byte is written, addresses end-of-file up to end-of-memory minus one are written with 0x00. The writes go in ascending order, one per cycle, with no gap.
- R6: When byte 11 is accepted, an end-of-file below 12 or an end-of-memory below end-of-file gives `err_code` 4, and byte 11 is not written.
- R7: `in_last` on an accepted byte whose offset is below end-of-file minus one gives `err_code` 5. That byte is still written.
- R8: `done` is high for exactly one cycle. That cycle is the one after the final memory write: the last zero write, or the last stored byte when the two pointers are equal. `start_pc` reads 0 before `done` and 12 from the `done` cycle onward.
- R9: After an error, `load_err` and `err_code` hold until reset. `in_ready` stays low, no memory write occurs, `done` never rises, and `start_pc` stays 0.
- R10: `in_ready` is high while the header and the stored bytes are being received. It goes low once the byte at end-of-file minus one is accepted, so bytes past end-of-file are never consumed.
- R11: During and right after reset, `in_ready` is 1 and `done`, `load_err`, `err_code`, `mem_we` and `start_pc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Image byte present |
| in_byte | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Loader accepts a byte this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle load-complete pulse |
| load_err | output | 1 | Load aborted |
| err_code | output | 3 | Abort cause: 1 signature, 2 revision, 3 pointer size, 4 layout, 5 truncated |
| start_pc | output | 32 | Initial program counter, valid from `done` on |

## Verification
A mis-captured pointer lane does not show at the ports until the stored section ends. It then appears as a write count that is off, a zero run that starts or stops at the wrong address, or a premature end of `in_ready`. So every load is compared against its full expected write sequence, not just the completion flags. A fault in the field checks appears within one cycle of the offending byte as a wrong `err_code` or a write that should have been suppressed. A fault in the fill counter appears in the very next `mem_addr`. The cycle distance between the final write and `done` is checked exactly, including the case with no zero region.

// File: rtl/ibl_pkg.sv
package ibl_pkg;
   typedef enum logic [2:0] {
      ST_HDR  = 3'd0,
      ST_TEXT = 3'd1,
      ST_FILL = 3'd2,
      ST_FIN  = 3'd3,
      ST_HOLD = 3'd4,
      ST_ERR  = 3'd5
   } ld_state_t;

   typedef enum logic [2:0] {
      E_NONE   = 3'd0,
      E_SIG    = 3'd1,
      E_REV    = 3'd2,
      E_PSZ    = 3'd3,
      E_LAYOUT = 3'd4,
      E_SHORT  = 3'd5
   } ld_err_t;
endpackage

// File: rtl/ibl_hdr_parse.sv
module ibl_hdr_parse
   import ibl_pkg::*;
#(
   parameter int PTR_BYTES = 4,
   parameter int REVISION  = 1,
   parameter logic [7:0] SIG0 = 8'h52,
   parameter logic [7:0] SIG1 = 8'h57,
   localparam int ADDR_W = 8 * PTR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_hdr,
   input  logic              cap,
   input  logic [ADDR_W-1:0] idx,
   input  logic [7:0]        byte_in,
   output logic [ADDR_W-1:0] eof_q,
   output logic [ADDR_W-1:0] eom_q,
   output logic [ADDR_W-1:0] eom_now,
   output ld_err_t           chk
);
   localparam int HDR_LEN  = 4 + 2 * PTR_BYTES;
   localparam int EOF_BASE = 4;
   localparam int EOM_BASE = 4 + PTR_BYTES;
   localparam logic [7:0] REV_CODE = 8'(97 + REVISION);
   localparam logic [7:0] PSZ_CODE = 8'(48 + $clog2(PTR_BYTES));

   if (PTR_BYTES != 1 && PTR_BYTES != 2 && PTR_BYTES != 4 && PTR_BYTES != 8) begin : g_bad_ptr
      $error("PTR_BYTES must be 1, 2, 4 or 8");
   end
   if (REVISION < 0 || REVISION > 158) begin : g_bad_rev
      $error("REVISION must fit in one header byte");
   end

   for (genvar g = 0; g < PTR_BYTES; g++) begin : g_lane
      logic [7:0] eof_b, eom_b;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            eof_b <= '0;
            eom_b <= '0;
         end else if (cap) begin
            if (idx == ADDR_W'(EOF_BASE + g)) eof_b <= byte_in;
            if (idx == ADDR_W'(EOM_BASE + g)) eom_b <= byte_in;
         end
      end
      assign eof_q[8*g +: 8]   = eof_b;
      assign eom_q[8*g +: 8]   = eom_b;
      assign eom_now[8*g +: 8] = (idx == ADDR_W'(EOM_BASE + g)) ? byte_in : eom_b;
   end

   always_comb begin
      chk = E_NONE;
      if (in_hdr) begin
         if (idx == ADDR_W'(0) && byte_in != SIG0)      chk = E_SIG;
         else if (idx == ADDR_W'(1) && byte_in != SIG1) chk = E_SIG;
         else if (idx == ADDR_W'(2) && byte_in != REV_CODE) chk = E_REV;
         else if (idx == ADDR_W'(3) && byte_in != PSZ_CODE) chk = E_PSZ;
         else if (idx == ADDR_W'(HDR_LEN - 1) &&
                  (eof_q < ADDR_W'(HDR_LEN) || eom_now < eof_q)) chk = E_LAYOUT;
      end
   end

   assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> ($stable(eof_q) && $stable(eom_q)));
endmodule

// File: rtl/ibl_zero_fill.sv
module ibl_zero_fill #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] first_addr,
   input  logic [ADDR_W-1:0] limit,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;

   assign we   = busy_q;
   assign addr = addr_q;
   assign last = busy_q && (addr_q == limit - ADDR_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         addr_q <= first_addr;
      end else if (busy_q) begin
         if (last) busy_q <= 1'b0;
         else      addr_q <= addr_q + ADDR_W'(1);
      end
   end

   assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (addr_q < limit));
   assert_fill_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/image_boot_loader.sv
module image_boot_loader
   import ibl_pkg::*;
#(
   parameter int PTR_BYTES = 4,
   parameter int REVISION  = 1,
   parameter logic [7:0] SIG0 = 8'h52,
   parameter logic [7:0] SIG1 = 8'h57,
   localparam int ADDR_W = 8 * PTR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              in_last,
   output logic              in_ready,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              done,
   output logic              load_err,
   output logic [2:0]        err_code,
   output logic [ADDR_W-1:0] start_pc
);
   localparam int HDR_LEN = 4 + 2 * PTR_BYTES;

   ld_state_t         state_q, state_d;
   ld_err_t           code_q, code_d, chk;
   logic [ADDR_W-1:0] ofs_q;
   logic [ADDR_W-1:0] eof_q, eom_q, eom_now;
   logic              accept, in_hdr, fmt_bad;
   logic              fill_start, fill_we, fill_last;
   logic [ADDR_W-1:0] fill_addr;

   assign in_ready = (state_q == ST_HDR) || (state_q == ST_TEXT);
   assign accept   = in_valid && in_ready;
   assign in_hdr   = (state_q == ST_HDR);
   assign fmt_bad  = accept && (chk != E_NONE);

   ibl_hdr_parse #(
      .PTR_BYTES(PTR_BYTES), .REVISION(REVISION), .SIG0(SIG0), .SIG1(SIG1)
   ) u_parse (
      .clk(clk), .rst_n(rst_n), .in_hdr(in_hdr),
      .cap(accept && in_hdr && !fmt_bad), .idx(ofs_q), .byte_in(in_byte),
      .eof_q(eof_q), .eom_q(eom_q), .eom_now(eom_now), .chk(chk)
   );

   ibl_zero_fill #(.ADDR_W(ADDR_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .start(fill_start), .first_addr(eof_q),
      .limit(eom_q), .we(fill_we), .addr(fill_addr), .last(fill_last)
   );

   always_comb begin
      state_d = state_q;
      code_d  = code_q;
      unique case (state_q)
         ST_HDR: if (accept) begin
            if (fmt_bad) begin
               state_d = ST_ERR;
               code_d  = chk;
            end else if (ofs_q == ADDR_W'(HDR_LEN - 1)) begin
               if (eof_q == ADDR_W'(HDR_LEN))
                  state_d = (eom_now == eof_q) ? ST_FIN : ST_FILL;
               else if (in_last) begin
                  state_d = ST_ERR;
                  code_d  = E_SHORT;
               end else
                  state_d = ST_TEXT;
            end else if (in_last) begin
               state_d = ST_ERR;
               code_d  = E_SHORT;
            end
         end
         ST_TEXT: if (accept) begin
            if (ofs_q == eof_q - ADDR_W'(1))
               state_d = (eom_q == eof_q) ? ST_FIN : ST_FILL;
            else if (in_last) begin
               state_d = ST_ERR;
               code_d  = E_SHORT;
            end
         end
         ST_FILL: if (fill_last) state_d = ST_FIN;
         ST_FIN:  state_d = ST_HOLD;
         default: state_d = state_q;
      endcase
   end

   assign fill_start = (state_d == ST_FILL) && (state_q != ST_FILL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HDR;
         code_q  <= E_NONE;
         ofs_q   <= '0;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
         if (accept) ofs_q <= ofs_q + ADDR_W'(1);
      end
   end

   assign mem_we    = (accept && !fmt_bad) || fill_we;
   assign mem_addr  = fill_we ? fill_addr : ofs_q;
   assign mem_wdata = fill_we ? 8'h00 : in_byte;
   assign done      = (state_q == ST_FIN);
   assign load_err  = (state_q == ST_ERR);
   assign err_code  = code_q;
   assign start_pc  = (state_q == ST_FIN || state_q == ST_HOLD) ? ADDR_W'(HDR_LEN) : '0;

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> (load_err && $stable(err_code)));
   assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> (!mem_we && !done));
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && start_pc == $past(start_pc)));
   assert_fill_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !in_ready) |-> (mem_wdata == 8'h00));
   assert_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_last && state_q == ST_TEXT && ofs_q != eof_q - ADDR_W'(1))
      |=> (load_err && err_code == 3'd5));
endmodule

// File: tb/tb_image_boot_loader.sv
module tb_image_boot_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_last = 1'b0;
   logic        in_ready, mem_we, done, load_err;
   logic [31:0] mem_addr, start_pc;
   logic [7:0]  mem_wdata;
   logic [2:0]  err_code;

   image_boot_loader dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_last(in_last), .in_ready(in_ready), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
      .load_err(load_err), .err_code(err_code), .start_pc(start_pc)
   );

   always #10 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   int n_wr = 0, last_wr_cyc = 0, done_cnt = 0, done_cyc = 0;
   int wr_addr [0:1023];
   int wr_data [0:1023];
   logic [7:0] img [0:511];
   bit finished = 0;

   always @(posedge clk) cyc++;

   always @(negedge clk) if (rst_n) begin
      if (mem_we) begin
         if (n_wr < 1024) begin
            wr_addr[n_wr] = int'(mem_addr);
            wr_data[n_wr] = int'(mem_wdata);
         end
         n_wr++;
         last_wr_cyc = cyc;
      end
      if (done) begin
         done_cnt++;
         done_cyc = cyc;
      end
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #5;
      rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      n_wr = 0; done_cnt = 0; done_cyc = 0; last_wr_cyc = 0;
      #4 rst_n = 1'b1;
   endtask

   task automatic build(int eof, int eom);
      img[0] = 8'h52; img[1] = 8'h57; img[2] = 8'd98; img[3] = 8'd50;
      for (int k = 0; k < 4; k++) begin
         img[4+k] = 8'((eof >> (8*k)) & 255);
         img[8+k] = 8'((eom >> (8*k)) & 255);
      end
      for (int k = 12; k < 512; k++) img[k] = 8'($urandom);
   endtask

   task automatic send(int n, int last_idx, bit gaps, output int acc);
      int i = 0;
      acc = 0;
      while (i < n) begin
         @(posedge clk); #5;
         if (gaps && ($urandom % 4) == 0) begin
            in_valid = 1'b0; in_last = 1'b0;
         end else begin
            in_valid = 1'b1; in_byte = img[i]; in_last = (i == last_idx);
            #5;
            if (in_ready) begin
               i++; acc++;
            end else break;
         end
      end
      @(posedge clk); #5;
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic verify_good(int eof, int eom, int acc, string tag);
      int bad = -1;
      repeat (eom - eof + 8) @(posedge clk);
      @(negedge clk);
      chk(acc == eof, "R10", {tag, " bytes consumed"}, acc, eof);
      chk(in_ready == 1'b0, "R10", {tag, " ready after load"}, in_ready, 0);
      chk(n_wr == eom, "R4", {tag, " write count"}, n_wr, eom);
      for (int k = 0; k < eof && k < n_wr; k++)
         if (bad < 0 && (wr_addr[k] != k || wr_data[k] != int'(img[k]))) bad = k;
      chk(bad < 0, "R4", {tag, " stored byte order, first bad index"}, bad, -1);
      bad = -1;
      for (int k = eof; k < eom && k < n_wr; k++)
         if (bad < 0 && (wr_addr[k] != k || wr_data[k] != 0)) bad = k;
      chk(bad < 0, "R5", {tag, " zero fill, first bad index"}, bad, -1);
      chk(done_cnt == 1, "R8", {tag, " done pulses"}, done_cnt, 1);
      chk(done_cyc == last_wr_cyc + 1, "R8", {tag, " done cycle"}, done_cyc, last_wr_cyc + 1);
      chk(start_pc == 32'd12, "R8", {tag, " start_pc"}, start_pc, 12);
      chk(load_err == 1'b0, "R8", {tag, " no error"}, load_err, 0);
   endtask

   task automatic verify_err(int code, int exp_wr, string req, string tag);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(load_err == 1'b1, req, {tag, " load_err"}, load_err, 1);
      chk(err_code == 3'(code), req, {tag, " err_code"}, err_code, code);
      chk(n_wr == exp_wr, req, {tag, " writes before abort"}, n_wr, exp_wr);
      chk(done_cnt == 0 && start_pc == 0, "R9", {tag, " no done, pc 0"}, done_cnt + start_pc, 0);
      chk(in_ready == 1'b0, "R9", {tag, " ready low"}, in_ready, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int acc;
      int eof, eom;
      void'($urandom(32'd20240611));
      #3;
      chk(in_ready == 1 && done == 0 && load_err == 0 && err_code == 0 &&
          mem_we == 0 && start_pc == 0, "R11", "outputs in reset", 0, 0);
      do_reset();
      @(negedge clk);
      chk(in_ready == 1 && done == 0 && load_err == 0 && start_pc == 0, "R11",
          "outputs after reset", start_pc, 0);

      // header only, no zero region: done right after byte 11
      build(12, 12); send(12, 11, 0, acc); verify_good(12, 12, acc, "R8 hdr-only");
      do_reset(); build(12, 20); send(12, 11, 0, acc); verify_good(12, 20, acc, "R5 hdr+fill");
      do_reset(); build(30, 30); send(30, 29, 1, acc); verify_good(30, 30, acc, "R4 no-fill");
      // extra bytes past end-of-file are not consumed
      do_reset(); build(20, 25); send(23, 22, 0, acc); verify_good(20, 25, acc, "R10 overrun");

      for (int r = 0; r < 10; r++) begin
         eof = 12 + int'($urandom % 70);
         eom = (r % 3 == 0) ? eof : eof + int'($urandom % 50);
         do_reset(); build(eof, eom);
         send(eof, eof - 1, 1, acc);
         verify_good(eof, eom, acc, "R4 random");
      end

      do_reset(); build(40, 50); img[0] = 8'h53; send(12, 11, 0, acc);
      verify_err(1, 0, "R1", "sig byte0");
      do_reset(); build(40, 50); img[1] = 8'h52; send(12, 11, 0, acc);
      verify_err(1, 1, "R1", "sig byte1");
      do_reset(); build(40, 50); img[2] = 8'd97; send(12, 11, 0, acc);
      verify_err(2, 2, "R2", "revision");
      do_reset(); build(40, 50); img[3] = 8'd51; send(12, 11, 0, acc);
      verify_err(3, 3, "R3", "ptr size");
      do_reset(); build(40, 39); send(12, 11, 0, acc);
      verify_err(4, 11, "R6", "eom below eof");
      do_reset(); build(5, 20); send(12, 11, 0, acc);
      verify_err(4, 11, "R6", "eof inside header");
      do_reset(); build(40, 60); send(26, 25, 0, acc);
      verify_err(5, 26, "R7", "short text");
      // more bytes after the abort must be refused
      send(5, 4, 0, acc);
      chk(acc == 0, "R9", "bytes taken after error", acc, 0);
      chk(n_wr == 26, "R9", "writes after error", n_wr, 26);
      do_reset(); build(40, 60); send(6, 5, 0, acc);
      verify_err(5, 6, "R7", "short header");
      do_reset(); build(13, 13); send(12, 11, 0, acc);
      verify_err(5, 12, "R7", "last on byte 11 with eof 13");

      // recovery after reset
      do_reset(); build(16, 18); send(16, 15, 0, acc); verify_good(16, 18, acc, "R11 reload");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule